// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog peripheral on an 8-bit I/O bus with 16-bit port addresses. It has two ports. The settings port is readable and writable and holds an enable bit and a period selector. The command port is write-only and reacts to two key bytes. The first key clears the count and withdraws the timeout. The second key halts the count, but only after software has already dropped the enable bit. Halting therefore needs two separate, deliberate writes.

While the watchdog runs, its counter advances once per system clock. If software does not write the clear key within the selected period, the counter reaches the period and stops there. The single-bit timeout output then rises and stays high until the next clear. The block leaves the watchdog running after reset, with the longest period selected. Whatever consumes the timeout (reset generation, for example) sits outside this block.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset, the settings port reads 0xFB and `wdt_timeout` is low. The watchdog is already running with period field 3, so `wdt_timeout` rises on the 2^(BASE_LOG2+6)-th clock edge after reset is released.
- R2: Only the low 8 address bits are decoded, so every upper byte mirrors the ports. The settings port is at low byte 0xF0 and the command port at low byte 0xF1. A write takes effect only when `bus_cs` and `bus_wr` are both high on the edge. Any other low byte, or a cycle without both strobes, changes nothing. `bus_rdata` shows the settings byte while `bus_cs` is high at the settings port, and shows 0 otherwise.
- R3: A settings write stores all 8 data bits, including bits 4:0, which have no function. Reading the settings port returns the stored byte.
- R4: Settings bits 6:5 hold a value n that selects a period of 2^(BASE_LOG2+2n) clock edges (2^16, 2^18, 2^20 or 2^22 by default). The live count is compared against the currently selected period.
- R5: A settings write that changes bit 7 (enable) from 0 to 1 zeroes the count, lowers `wdt_timeout` and starts counting.
- R6: Writing 0x4E to the command port zeroes the count and lowers `wdt_timeout`. If the enable bit is set, counting (re)starts for a full period. If the enable bit is clear, a halted counter stays halted.
- R7: Writing 0xB1 to the command port halts the counter when the enable bit is 0. When the enable bit is 1, the write is ignored.
- R8: Any command byte other than 0x4E and 0xB1 changes neither `wdt_timeout`, the settings byte nor the count.
- R9: Clearing the enable bit by a settings write does not halt a running count. It still times out unless it is halted or cleared.
- R10: When the count reaches the selected period, `wdt_timeout` rises and the counter holds without wrapping. `wdt_timeout` stays high until a clear key or a 0-to-1 enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select for both ports |
| bus_wr | input | 1 | Write strobe, qualified by `bus_cs` |
| bus_addr | input | 16 | Port address; only the low byte is decoded |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Settings byte when selected, else 0 |
| wdt_timeout | output | 1 | Active-high timeout flag, synchronous |

## Verification
The bound checker watches every cycle for the following: a settings write landing exactly as written, the settings byte staying unchanged on any other cycle, and the clear key always leaving a zero count with the flag low. It also checks that an honoured halt key stops the counter, that dropping the enable bit never halts a running count, that the timeout flag never falls except after a clear, and that the count never passes the longest period. The exact edge on which the timeout rises for each period selection, the key being refused while the enable bit is set, and the restart after a 0-to-1 enable can only be shown by the bench's timed scenarios. The bench runs these with a shortened base period, mixing directed sequences with random period fields, upper address bytes and spare bits.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

    // Decoded action requested by a write to the command port
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_STOP  = 2'd2
    } wdt_cmd_e;

endpackage

// File: rtl/wdt_port_decode.sv
module wdt_port_decode
    import wdt_keyed_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 DATA_W    = 8,
    parameter int                 PORT_W    = 8,
    parameter logic [PORT_W-1:0]  MODE_PORT = 8'hF0,
    parameter logic [PORT_W-1:0]  CMD_PORT  = 8'hF1,
    parameter logic [DATA_W-1:0]  KEY_CLEAR = 8'h4E,
    parameter logic [DATA_W-1:0]  KEY_STOP  = 8'hB1
) (
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              mode_sel,
    output logic              mode_wr,
    output wdt_cmd_e          cmd
);

    // Upper address bits are masked away so the ports mirror across them
    localparam logic [ADDR_W-1:0] PORT_MASK = ADDR_W'((1 << PORT_W) - 1);

    logic cmd_wr;

    always_comb begin
        mode_sel = bus_cs && ((bus_addr & PORT_MASK) == ADDR_W'(MODE_PORT));
        mode_wr  = mode_sel && bus_wr;
        cmd_wr   = bus_cs && bus_wr && ((bus_addr & PORT_MASK) == ADDR_W'(CMD_PORT));
        cmd      = CMD_NONE;
        if (cmd_wr) begin
            if (bus_wdata == KEY_CLEAR) begin
                cmd = CMD_CLEAR;
            end else if (bus_wdata == KEY_STOP) begin
                cmd = CMD_STOP;
            end
        end
    end

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel #(
    parameter int BASE_LOG2 = 16,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = BASE_LOG2 + 2 * ((1 << SEL_W) - 1) + 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] limit
);

    localparam int N_SEL = 1 << SEL_W;

    logic [CNT_W-1:0] period_tbl [N_SEL];

    // Each selector step lengthens the period by a factor of four
    for (genvar g = 0; g < N_SEL; g++) begin : g_period
        assign period_tbl[g] = CNT_W'(1) << (BASE_LOG2 + 2 * g);
    end

    assign limit = period_tbl[sel];

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
    import wdt_keyed_pkg::*;
#(
    parameter int                 ADDR_W     = 16,
    parameter int                 DATA_W     = 8,
    parameter int                 PORT_W     = 8,
    parameter logic [PORT_W-1:0]  MODE_PORT  = 8'hF0,
    parameter logic [PORT_W-1:0]  CMD_PORT   = 8'hF1,
    parameter logic [DATA_W-1:0]  KEY_CLEAR  = 8'h4E,
    parameter logic [DATA_W-1:0]  KEY_STOP   = 8'hB1,
    parameter logic [DATA_W-1:0]  MODE_RESET = 8'hFB,
    parameter int                 EN_BIT     = 7,
    parameter int                 SEL_LSB    = 5,
    parameter int                 SEL_W      = 2,
    parameter int                 BASE_LOG2  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_timeout
);

    // Wide enough to hold the longest period value itself
    localparam int CNT_W = BASE_LOG2 + 2 * ((1 << SEL_W) - 1) + 1;

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic              run;
        logic              expired;
        logic [CNT_W-1:0]  count;
    } wdt_state_t;

    localparam wdt_state_t ST_RESET = '{
        mode:    MODE_RESET,
        run:     MODE_RESET[EN_BIT],
        expired: 1'b0,
        count:   '0
    };

    wdt_state_t       st_d;
    wdt_state_t       st_q;
    logic             mode_sel;
    logic             mode_wr;
    wdt_cmd_e         cmd;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count_nx;
    logic             enable_rise;

    wdt_port_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_W   (PORT_W),
        .MODE_PORT(MODE_PORT),
        .CMD_PORT (CMD_PORT),
        .KEY_CLEAR(KEY_CLEAR),
        .KEY_STOP (KEY_STOP)
    ) u_decode (
        .bus_cs   (bus_cs),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .mode_sel (mode_sel),
        .mode_wr  (mode_wr),
        .cmd      (cmd)
    );

    wdt_period_sel #(
        .BASE_LOG2(BASE_LOG2),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_period (
        .sel  (st_q.mode[SEL_LSB +: SEL_W]),
        .limit(limit)
    );

    always_comb begin
        st_d        = st_q;
        count_nx    = st_q.count + CNT_W'(1);
        enable_rise = mode_wr && !st_q.mode[EN_BIT] && bus_wdata[EN_BIT];

        // Free-running count; stops and holds on reaching the period
        if (st_q.run) begin
            st_d.count = count_nx;
            if (count_nx >= limit) begin
                st_d.expired = 1'b1;
                st_d.run     = 1'b0;
            end
        end

        // Settings write; a rising enable restarts from zero
        if (mode_wr) begin
            st_d.mode = bus_wdata;
            if (enable_rise) begin
                st_d.count   = '0;
                st_d.expired = 1'b0;
                st_d.run     = 1'b1;
            end
        end

        // Key commands
        case (cmd)
            CMD_CLEAR: begin
                st_d.count   = '0;
                st_d.expired = 1'b0;
                st_d.run     = st_q.run || st_q.mode[EN_BIT];
            end
            CMD_STOP: begin
                if (!st_q.mode[EN_BIT]) begin
                    st_d.run = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = mode_sel ? st_q.mode : '0;
    assign wdt_timeout = st_q.expired;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int                 ADDR_W    = 16,
    parameter int                 DATA_W    = 8,
    parameter int                 PORT_W    = 8,
    parameter logic [PORT_W-1:0]  MODE_PORT = 8'hF0,
    parameter logic [PORT_W-1:0]  CMD_PORT  = 8'hF1,
    parameter logic [DATA_W-1:0]  KEY_CLEAR = 8'h4E,
    parameter logic [DATA_W-1:0]  KEY_STOP  = 8'hB1,
    parameter int                 EN_BIT    = 7,
    parameter int                 CNT_W     = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              wdt_timeout,
    input logic [DATA_W-1:0] mode_q,
    input logic              run_q,
    input logic [CNT_W-1:0]  count_q
);

    localparam logic [ADDR_W-1:0] PORT_MASK = ADDR_W'((1 << PORT_W) - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(1) << (CNT_W - 1);

    logic wr_mode;
    logic wr_cmd;
    logic key_clear;
    logic key_stop;
    logic en_rise;

    assign wr_mode   = bus_cs && bus_wr && ((bus_addr & PORT_MASK) == ADDR_W'(MODE_PORT));
    assign wr_cmd    = bus_cs && bus_wr && ((bus_addr & PORT_MASK) == ADDR_W'(CMD_PORT));
    assign key_clear = wr_cmd && (bus_wdata == KEY_CLEAR);
    assign key_stop  = wr_cmd && (bus_wdata == KEY_STOP);
    assign en_rise   = wr_mode && !mode_q[EN_BIT] && bus_wdata[EN_BIT];

    a_r3_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (mode_q == $past(bus_wdata)));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));

    a_r6_clear_key: assert property (@(posedge clk) disable iff (!rst_n)
        key_clear |=> (!wdt_timeout && (count_q == '0)));

    a_r7_stop_key: assert property (@(posedge clk) disable iff (!rst_n)
        (key_stop && !mode_q[EN_BIT]) |=> !run_q);

    a_r9_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && mode_q[EN_BIT] && !bus_wdata[EN_BIT] && run_q) |=> (run_q || wdt_timeout));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && !key_clear && !en_rise) |=> wdt_timeout);

    a_r10_halt_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_timeout) |-> !run_q);

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PORT_W   (PORT_W),
    .MODE_PORT(MODE_PORT),
    .CMD_PORT (CMD_PORT),
    .KEY_CLEAR(KEY_CLEAR),
    .KEY_STOP (KEY_STOP),
    .EN_BIT   (EN_BIT),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs     (bus_cs),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .wdt_timeout(wdt_timeout),
    .mode_q     (st_q.mode),
    .run_q      (st_q.run),
    .count_q    (st_q.count)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BL         = 4;
    localparam int MAX_CYC    = 150000;

    logic        clk;
    logic        rst_n;
    logic        cs;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        tmo;

    int n_chk;
    int n_bad;
    bit done;

    wdt_keyed_top #(.BASE_LOG2(BL)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_cs     (cs),
        .bus_wr     (wr),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .wdt_timeout(tmo)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int period_of(logic [7:0] m);
        return 1 << (BL + 2 * int'(m[6:5]));
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Caller sits at a negedge; the write lands on the following posedge
    task automatic wr_bus(logic [15:0] a, logic [7:0] d);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    // Raw cycle with arbitrary strobes
    task automatic raw_cycle(logic c, logic w, logic [15:0] a, logic [7:0] d);
        cs = c; wr = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_mode(logic [15:0] a, output logic [7:0] v);
        cs = 1'b1; wr = 1'b0; addr = a;
        #1;
        v = rdata;
        cs = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Timeout expected exactly 'remaining' edges from now
    task automatic expect_expiry(int remaining, string req);
        repeat (remaining - 1) @(posedge clk);
        @(negedge clk);
        chk(req, 32'(tmo), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk(req, 32'(tmo), 32'd1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        n_chk = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0; cs = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and running longest period
        chk("R1", 32'(tmo), 32'd0);
        rd_mode(16'h00F0, v);
        chk("R1", 32'(v), 32'hFB);
        expect_expiry(1 << (BL + 6), "R1");

        // R10: sticky timeout
        idle(40);
        chk("R10", 32'(tmo), 32'd1);

        // R8: stray command bytes, stop key refused while enabled
        wr_bus(16'h00F1, 8'h00);
        wr_bus(16'h12F1, 8'h4F);
        wr_bus(16'hFFF1, 8'hB0);
        wr_bus(16'h00F1, 8'hB1);
        chk("R8", 32'(tmo), 32'd1);
        rd_mode(16'h00F0, v);
        chk("R8", 32'(v), 32'hFB);

        // R6: clear key at a mirrored address restarts a full period
        wr_bus(16'hA5F1, 8'h4E);
        chk("R6", 32'(tmo), 32'd0);
        expect_expiry(1 << (BL + 6), "R6");

        // R2: missing strobes, wrong low byte, mirrored read
        raw_cycle(1'b0, 1'b1, 16'h00F1, 8'h4E);
        chk("R2", 32'(tmo), 32'd1);
        raw_cycle(1'b1, 1'b0, 16'h00F1, 8'h4E);
        chk("R2", 32'(tmo), 32'd1);
        wr_bus(16'h00F2, 8'h4E);
        chk("R2", 32'(tmo), 32'd1);
        wr_bus(16'h00F3, 8'h00);
        rd_mode(16'h7FF0, v);
        chk("R2", 32'(v), 32'hFB);
        rd_mode(16'h00F1, v);
        chk("R2", 32'(v), 32'h00);

        // R3: all bits stored; dropping enable does not clear the flag
        wr_bus(16'h3CF0, 8'h7C);
        rd_mode(16'h00F0, v);
        chk("R3", 32'(v), 32'h7C);
        chk("R3", 32'(tmo), 32'd1);

        // R5: rising enable restarts; then halt via two-step sequence (R7)
        wr_bus(16'h00F0, 8'h83);
        chk("R5", 32'(tmo), 32'd0);
        wr_bus(16'h00F1, 8'h4E);
        wr_bus(16'h00F0, 8'h03);
        wr_bus(16'h00F1, 8'hB1);
        idle(100);
        chk("R7", 32'(tmo), 32'd0);
        wr_bus(16'h00F1, 8'h4E);
        idle(100);
        chk("R6", 32'(tmo), 32'd0);
        wr_bus(16'h00F0, 8'h83);
        expect_expiry(16, "R5");

        // R9: enable dropped while running still expires
        wr_bus(16'h00F1, 8'h4E);
        wr_bus(16'h00F0, 8'h03);
        expect_expiry(15, "R9");

        // R7: stop key ignored while enabled
        wr_bus(16'h00F0, 8'hA3);
        wr_bus(16'h00F1, 8'hB1);
        expect_expiry(63, "R7");

        // R4: shortening the period on a live count
        wr_bus(16'h00F1, 8'h4E);
        wr_bus(16'h00F0, 8'h83);
        expect_expiry(15, "R4");

        // R4/R3/R2: random period fields, spare bits, upper bytes
        for (int i = 0; i < 12; i++) begin
            logic [1:0] n;
            logic [7:0] up;
            logic [7:0] lo;
            logic [7:0] m;
            n  = 2'($urandom_range(0, 3));
            up = 8'($urandom_range(0, 255));
            lo = 8'($urandom);
            m  = {1'b1, n, lo[4:0]};
            wr_bus({8'($urandom), 8'hF0}, {1'b0, n, lo[4:0]});
            wr_bus({8'($urandom), 8'hF1}, 8'hB1);
            idle(int'($urandom_range(0, 5)));
            wr_bus({up, 8'hF0}, m);
            rd_mode({8'($urandom), 8'hF0}, v);
            chk("R3", 32'(v), 32'(m));
            expect_expiry(period_of(m), "R4");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule